// File: doc/BRIEF.md
# Buffered SPI Target Transfer Engine

This block is the serial side of an SPI target. An external master frames a transfer by pulling the chip-select low. While the frame lasts, the block shifts out bytes taken from a transmit buffer and collects incoming bytes into a receive buffer. Each buffer has its own programmable byte limit. Once the master has clocked more bytes than a limit allows, the block protects that buffer. On the transmit side it sends a fixed fill character. On the receive side it drops the byte. In both cases it raises a sticky flag.

All four combinations of clock polarity and phase are supported, in either bit order. The SPI pins are sampled into the system clock domain, so SCK must be several times slower than the system clock. The buffers sit outside the block and are reached through a byte read port with one cycle of latency and a byte write port. Buffer ownership is decided elsewhere and arrives as a grant level. A frame that starts without the grant stores nothing and answers every byte with a second fill character. When a granted frame ends, the block reports how many bytes it moved in each direction and gives a one-cycle end pulse.

Top module: `spi_target_engine`

## Requirements
- R1: After synchronous reset the outputs are in their idle state: MISO 0, no end pulse, both flags 0, both amounts 0, and no buffer read or write.
- R2: In a granted frame, completed received byte k (counted from 0) is written to the receive port at address k with its value, for every k below the receive limit, in order.
- R3: The mode input selects the SPI mode. Bit 1 gives the idle SCK level and bit 0 selects sampling on the trailing edge (1) or the leading edge (0). In all four modes, transmit byte k below the transmit limit comes from buffer address k. MISO changes on the edge opposite to the sampling edge.
- R4: With the order input at 1, each byte is shifted least significant bit first in both directions. At 0, the most significant bit goes first.
- R5: A received byte with index at or above the receive limit is not written, and it sets the overflow flag.
- R6: A transmit byte with index at or above the transmit limit is replaced on MISO by the over-read character. Clocking such a byte to completion sets the over-read flag.
- R7: At the end of a granted frame, the received amount becomes min(completed bytes, receive limit) and the transmitted amount becomes min(completed bytes, transmit limit). Both hold until the next granted frame ends.
- R8: Each granted frame produces exactly one end pulse, one cycle wide, after chip-select returns high.
- R9: A frame that begins with grant low sends the default character for every byte. It makes no buffer access and no end pulse, and it leaves the flags and amounts unchanged.
- R10: The flags stay set until cleared. Writing 1 to clear bit 0 clears over-read, and writing 1 to clear bit 1 clears overflow. Each clear bit affects only its own flag.
- R11: The transmit buffer is read only at addresses below the transmit limit. Read data is taken one cycle after the read enable.
- R12: Each falling edge of chip-select restarts the bit and byte counts. A trailing partial byte is discarded and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | SPI clock from master (asynchronous) |
| csn_i | input | 1 | Chip-select, active low (asynchronous) |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| mode_i | input | 2 | Bit 1 idle clock level, bit 0 trailing-edge sampling |
| lsb_first_i | input | 1 | 1: least significant bit first |
| grant_i | input | 1 | Buffer ownership granted to the engine |
| tx_limit_i | input | IDX_W | Transmit buffer byte limit |
| rx_limit_i | input | IDX_W | Receive buffer byte limit |
| ovr_char_i | input | 8 | Byte sent past the transmit limit |
| def_char_i | input | 8 | Byte sent in an ungranted frame |
| tx_rd_en_o | output | 1 | Transmit buffer read strobe |
| tx_rd_addr_o | output | IDX_W | Transmit buffer read address |
| tx_rd_data_i | input | 8 | Read data, valid the cycle after the strobe |
| rx_wr_en_o | output | 1 | Receive buffer write strobe |
| rx_wr_addr_o | output | IDX_W | Receive buffer write address |
| rx_wr_data_o | output | 8 | Receive buffer write data |
| tx_count_o | output | IDX_W | Bytes sent from the buffer in the last granted frame |
| rx_count_o | output | IDX_W | Bytes stored in the last granted frame |
| end_o | output | 1 | One-cycle pulse at the end of a granted frame |
| flag_overread_o | output | 1 | Sticky transmit over-read flag |
| flag_overflow_o | output | 1 | Sticky receive overflow flag |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 over-read, bit 1 overflow |

## Verification
If the receive bit counter slips, the next completed byte reaches the write port with shifted bits or at the wrong address. The scoreboard sees this within one byte time. A bad transmit prefetch or load point corrupts the first MISO bit of the following byte, and the master model catches it when that byte completes. Errors in the byte counter or in the limit compares show only at frame end, in the amounts, the flags and the count of write strobes. Every frame is therefore followed by checks on all three.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef struct packed {
    logic idle_high;   // clock idle level
    logic late_sample; // sample on trailing edge
    logic lsb_first;
  } spt_cfg_t;
endpackage

// File: rtl/spt_sync.sv
module spt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spt_frame.sv
module spt_frame
  import spt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sck_i,
  input  logic     csn_i,
  input  logic     mosi_i,
  input  spt_cfg_t cfg_i,
  input  logic     grant_i,
  output logic     start_o,
  output logic     stop_o,
  output logic     active_o,
  output logic     smp_evt_o,
  output logic     drv_evt_o,
  output logic     mosi_s_o,
  output spt_cfg_t cfg_o,
  output logic     grant_o
);
  logic [2:0] pins_s;
  logic sck_s, csn_s;
  logic sck_d, csn_d;
  logic rise, fall, lead, trail;

  spt_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sck_i, csn_i, mosi_i}),
    .q_o (pins_s)
  );

  assign sck_s    = pins_s[2];
  assign csn_s    = pins_s[1];
  assign mosi_s_o = pins_s[0];

  assign rise  = ~sck_d & sck_s;
  assign fall  = sck_d & ~sck_s;
  assign lead  = cfg_o.idle_high ? fall : rise;
  assign trail = cfg_o.idle_high ? rise : fall;

  assign start_o   = csn_d & ~csn_s;
  assign stop_o    = ~csn_d & csn_s & active_o;
  assign smp_evt_o = active_o & ~stop_o & (cfg_o.late_sample ? trail : lead);
  assign drv_evt_o = active_o & ~stop_o & (cfg_o.late_sample ? lead : trail);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      csn_d    <= 1'b1;
      active_o <= 1'b0;
      cfg_o    <= '0;
      grant_o  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      csn_d <= csn_s;
      if (start_o) begin
        active_o <= 1'b1;
        cfg_o    <= cfg_i;
        grant_o  <= grant_i;
      end else if (stop_o) begin
        active_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spt_txpath.sv
module spt_txpath
  import spt_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              active_i,
  input  logic              drv_evt_i,
  input  logic              late_sample_i,
  input  logic              lsb_first_i,
  input  logic              grant_i,
  input  logic [IDX_W-1:0]  tx_limit_i,
  input  logic [BYTE_W-1:0] ovr_char_i,
  input  logic [BYTE_W-1:0] def_char_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_addr_o,
  output logic              miso_o
);
  logic [IDX_W-1:0]     fetch_idx;
  logic [BYTE_W-1:0]    nxt_byte;
  logic                 nxt_valid;
  logic                 rd_wait;
  logic [BYTE_W-1:0]    shreg, shreg_n;
  logic [BIT_CNT_W-1:0] bitpos, bitpos_n;
  logic                 first_pend;
  logic                 issue, from_mem, ld_first, ld_edge, load, out_bit;

  assign issue    = active_i & ~nxt_valid & ~rd_en_o & ~rd_wait;
  assign from_mem = grant_i & (fetch_idx < tx_limit_i);
  assign ld_first = first_pend & ~late_sample_i & nxt_valid;
  assign ld_edge  = drv_evt_i & (late_sample_i ? (bitpos == '0) : (bitpos == '1));
  assign load     = ld_first | ld_edge;

  always_comb begin
    shreg_n  = shreg;
    bitpos_n = bitpos;
    if (load) begin
      shreg_n = nxt_byte;
    end else if (drv_evt_i) begin
      shreg_n = lsb_first_i ? {1'b0, shreg[BYTE_W-1:1]} : {shreg[BYTE_W-2:0], 1'b0};
    end
    if (ld_first) bitpos_n = '0;
    else if (drv_evt_i) bitpos_n = bitpos + 1'b1;
    out_bit = lsb_first_i ? shreg_n[0] : shreg_n[BYTE_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_idx  <= '0;
      nxt_byte   <= '0;
      nxt_valid  <= 1'b0;
      rd_en_o    <= 1'b0;
      rd_addr_o  <= '0;
      rd_wait    <= 1'b0;
      shreg      <= '0;
      bitpos     <= '0;
      first_pend <= 1'b0;
      miso_o     <= 1'b0;
    end else if (start_i) begin
      fetch_idx  <= '0;
      nxt_valid  <= 1'b0;
      rd_en_o    <= 1'b0;
      rd_wait    <= 1'b0;
      shreg      <= '0;
      bitpos     <= '0;
      first_pend <= 1'b1;
      miso_o     <= 1'b0;
    end else begin
      rd_en_o <= issue & from_mem;
      rd_wait <= rd_en_o;
      if (issue) begin
        rd_addr_o <= fetch_idx;
        fetch_idx <= (fetch_idx == '1) ? fetch_idx : fetch_idx + 1'b1;
        if (!from_mem) begin
          nxt_byte  <= grant_i ? ovr_char_i : def_char_i;
          nxt_valid <= 1'b1;
        end
      end
      if (rd_wait) begin
        nxt_byte  <= rd_data_i;
        nxt_valid <= 1'b1;
      end
      if (load) begin
        nxt_valid  <= 1'b0;
        first_pend <= 1'b0;
      end
      shreg  <= stop_i ? '0 : shreg_n;
      bitpos <= bitpos_n;
      miso_o <= active_i & ~stop_i & out_bit;
    end
  end
endmodule

// File: rtl/spt_rxpath.sv
module spt_rxpath
  import spt_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              smp_evt_i,
  input  logic              mosi_i,
  input  logic              lsb_first_i,
  input  logic              grant_i,
  input  logic [IDX_W-1:0]  rx_limit_i,
  input  logic [IDX_W-1:0]  tx_limit_i,
  input  logic [1:0]        clr_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [IDX_W-1:0]  rx_count_o,
  output logic [IDX_W-1:0]  tx_count_o,
  output logic              end_o,
  output logic              flag_ovr_o,
  output logic              flag_ovf_o
);
  logic [BYTE_W-1:0]    rshreg, rshreg_n;
  logic [BIT_CNT_W-1:0] rbit;
  logic [IDX_W-1:0]     byte_cnt;
  logic                 byte_done, in_rx, in_tx, ovf_set, ovr_set;

  assign rshreg_n  = lsb_first_i ? {mosi_i, rshreg[BYTE_W-1:1]} : {rshreg[BYTE_W-2:0], mosi_i};
  assign byte_done = smp_evt_i & (rbit == '1);
  assign in_rx     = byte_cnt < rx_limit_i;
  assign in_tx     = byte_cnt < tx_limit_i;
  assign ovf_set   = byte_done & grant_i & ~in_rx;
  assign ovr_set   = byte_done & grant_i & ~in_tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rshreg     <= '0;
      rbit       <= '0;
      byte_cnt   <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      rx_count_o <= '0;
      tx_count_o <= '0;
      end_o      <= 1'b0;
      flag_ovr_o <= 1'b0;
      flag_ovf_o <= 1'b0;
    end else begin
      wr_en_o    <= 1'b0;
      end_o      <= 1'b0;
      flag_ovf_o <= ovf_set | (flag_ovf_o & ~clr_i[1]);
      flag_ovr_o <= ovr_set | (flag_ovr_o & ~clr_i[0]);
      if (start_i) begin
        rshreg   <= '0;
        rbit     <= '0;
        byte_cnt <= '0;
      end else if (smp_evt_i) begin
        rshreg <= rshreg_n;
        rbit   <= rbit + 1'b1;
        if (byte_done) begin
          byte_cnt <= (byte_cnt == '1) ? byte_cnt : byte_cnt + 1'b1;
          if (grant_i && in_rx) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= byte_cnt;
            wr_data_o <= rshreg_n;
          end
        end
      end
      if (stop_i && grant_i) begin
        end_o      <= 1'b1;
        rx_count_o <= in_rx ? byte_cnt : rx_limit_i;
        tx_count_o <= in_tx ? byte_cnt : tx_limit_i;
      end
    end
  end
endmodule

// File: rtl/spi_target_engine.sv
module spi_target_engine
  import spt_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  output logic             miso_o,
  input  logic [1:0]       mode_i,
  input  logic             lsb_first_i,
  input  logic             grant_i,
  input  logic [IDX_W-1:0] tx_limit_i,
  input  logic [IDX_W-1:0] rx_limit_i,
  input  logic [7:0]       ovr_char_i,
  input  logic [7:0]       def_char_i,
  output logic             tx_rd_en_o,
  output logic [IDX_W-1:0] tx_rd_addr_o,
  input  logic [7:0]       tx_rd_data_i,
  output logic             rx_wr_en_o,
  output logic [IDX_W-1:0] rx_wr_addr_o,
  output logic [7:0]       rx_wr_data_o,
  output logic [IDX_W-1:0] tx_count_o,
  output logic [IDX_W-1:0] rx_count_o,
  output logic             end_o,
  output logic             flag_overread_o,
  output logic             flag_overflow_o,
  input  logic [1:0]       flag_clr_i
);
  spt_cfg_t cfg_in, cfg_l;
  logic start, stop, active, smp_evt, drv_evt, mosi_s, grant_l;

  assign cfg_in = '{idle_high: mode_i[1], late_sample: mode_i[0], lsb_first: lsb_first_i};

  spt_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .sck_i     (sck_i),
    .csn_i     (csn_i),
    .mosi_i    (mosi_i),
    .cfg_i     (cfg_in),
    .grant_i   (grant_i),
    .start_o   (start),
    .stop_o    (stop),
    .active_o  (active),
    .smp_evt_o (smp_evt),
    .drv_evt_o (drv_evt),
    .mosi_s_o  (mosi_s),
    .cfg_o     (cfg_l),
    .grant_o   (grant_l)
  );

  spt_txpath #(.IDX_W(IDX_W)) u_tx (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start),
    .stop_i        (stop),
    .active_i      (active),
    .drv_evt_i     (drv_evt),
    .late_sample_i (cfg_l.late_sample),
    .lsb_first_i   (cfg_l.lsb_first),
    .grant_i       (grant_l),
    .tx_limit_i    (tx_limit_i),
    .ovr_char_i    (ovr_char_i),
    .def_char_i    (def_char_i),
    .rd_data_i     (tx_rd_data_i),
    .rd_en_o       (tx_rd_en_o),
    .rd_addr_o     (tx_rd_addr_o),
    .miso_o        (miso_o)
  );

  spt_rxpath #(.IDX_W(IDX_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .stop_i      (stop),
    .smp_evt_i   (smp_evt),
    .mosi_i      (mosi_s),
    .lsb_first_i (cfg_l.lsb_first),
    .grant_i     (grant_l),
    .rx_limit_i  (rx_limit_i),
    .tx_limit_i  (tx_limit_i),
    .clr_i       (flag_clr_i),
    .wr_en_o     (rx_wr_en_o),
    .wr_addr_o   (rx_wr_addr_o),
    .wr_data_o   (rx_wr_data_o),
    .rx_count_o  (rx_count_o),
    .tx_count_o  (tx_count_o),
    .end_o       (end_o),
    .flag_ovr_o  (flag_overread_o),
    .flag_ovf_o  (flag_overflow_o)
  );
endmodule

// File: rtl/spt_chk.sv
module spt_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             csn_i,
  input logic             miso_o,
  input logic             grant_i,
  input logic [IDX_W-1:0] tx_limit_i,
  input logic [IDX_W-1:0] rx_limit_i,
  input logic             tx_rd_en_o,
  input logic [IDX_W-1:0] tx_rd_addr_o,
  input logic             rx_wr_en_o,
  input logic [IDX_W-1:0] rx_wr_addr_o,
  input logic [IDX_W-1:0] tx_count_o,
  input logic [IDX_W-1:0] rx_count_o,
  input logic             end_o,
  input logic             flag_overread_o,
  input logic             flag_overflow_o,
  input logic [1:0]       flag_clr_i
);
  p_rd_below_limit_r11: assert property (@(posedge clk) disable iff (rst)
    tx_rd_en_o |-> (tx_rd_addr_o < tx_limit_i));

  p_wr_below_limit_r5: assert property (@(posedge clk) disable iff (rst)
    rx_wr_en_o |-> (rx_wr_addr_o < rx_limit_i));

  p_no_access_ungranted_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_rd_en_o || rx_wr_en_o) |-> grant_i);

  p_end_single_r8: assert property (@(posedge clk) disable iff (rst)
    end_o |=> !end_o);

  p_amount_capped_r7: assert property (@(posedge clk) disable iff (rst)
    end_o |-> (tx_count_o <= tx_limit_i) && (rx_count_o <= rx_limit_i));

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_overread_o && !flag_clr_i[0]) |=> flag_overread_o);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_overflow_o && !flag_clr_i[1]) |=> flag_overflow_o);

  p_idle_miso_r12: assert property (@(posedge clk) disable iff (rst)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) && $past(csn_i, 4)) |-> !miso_o);
endmodule

bind spi_target_engine spt_chk #(.IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .csn_i           (csn_i),
  .miso_o          (miso_o),
  .grant_i         (grant_i),
  .tx_limit_i      (tx_limit_i),
  .rx_limit_i      (rx_limit_i),
  .tx_rd_en_o      (tx_rd_en_o),
  .tx_rd_addr_o    (tx_rd_addr_o),
  .rx_wr_en_o      (rx_wr_en_o),
  .rx_wr_addr_o    (rx_wr_addr_o),
  .tx_count_o      (tx_count_o),
  .rx_count_o      (rx_count_o),
  .end_o           (end_o),
  .flag_overread_o (flag_overread_o),
  .flag_overflow_o (flag_overflow_o),
  .flag_clr_i      (flag_clr_i)
);

// File: tb/sim_spi_target_engine.sv
`timescale 1ns/1ps
module sim_spi_target_engine;
  localparam int IW = 8;
  localparam int HALF = 10;
  localparam logic [7:0] DEFC = 8'h5C;
  localparam logic [7:0] OVRC = 8'hE7;

  logic clk = 1'b0;
  logic rst;
  logic sck, csn, mosi, miso;
  logic [1:0] mode;
  logic lsb, grant;
  logic [IW-1:0] txl, rxl;
  logic tx_rd_en, rx_wr_en, end_p, f_ovr, f_ovf;
  logic [IW-1:0] tx_rd_addr, rx_wr_addr, tx_cnt, rx_cnt;
  logic [7:0] tx_rd_data, rx_wr_data;
  logic [1:0] clr;

  always #10 clk = ~clk;

  spi_target_engine #(.IDX_W(IW)) u0 (
    .clk (clk), .rst (rst), .sck_i (sck), .csn_i (csn), .mosi_i (mosi), .miso_o (miso),
    .mode_i (mode), .lsb_first_i (lsb), .grant_i (grant),
    .tx_limit_i (txl), .rx_limit_i (rxl), .ovr_char_i (OVRC), .def_char_i (DEFC),
    .tx_rd_en_o (tx_rd_en), .tx_rd_addr_o (tx_rd_addr), .tx_rd_data_i (tx_rd_data),
    .rx_wr_en_o (rx_wr_en), .rx_wr_addr_o (rx_wr_addr), .rx_wr_data_o (rx_wr_data),
    .tx_count_o (tx_cnt), .rx_count_o (rx_cnt), .end_o (end_p),
    .flag_overread_o (f_ovr), .flag_overflow_o (f_ovf), .flag_clr_i (clr)
  );

  // transmit buffer model: registered read, one cycle latency (R11)
  logic [7:0] txm [0:255];
  initial for (int i = 0; i < 256; i++) txm[i] = 8'(i * 37 + 11);
  always @(posedge clk) if (tx_rd_en) tx_rd_data <= txm[tx_rd_addr];

  int nvec = 0;
  int nfail = 0;
  int ends = 0;
  bit prev_end = 1'b0;
  bit mdl_ovf = 1'b0;
  bit mdl_ovr = 1'b0;
  logic [15:0] exp_q [$];
  logic [7:0] mo [0:15];
  logic [7:0] mi [0:15];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard on the receive write port and end pulses
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_wr_en) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected rx write addr", int'(rx_wr_addr), -1);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({rx_wr_addr, rx_wr_data} == e, "R2", "rx write {addr,data}",
              int'({rx_wr_addr, rx_wr_data}), int'(e));
        end
      end
      if (end_p) ends++;
      if (end_p && prev_end) chk(1'b0, "R8", "end pulse wider than one cycle", 2, 1);
      prev_end = end_p;
    end
  end

  task automatic spi_run(input int nbits, input bit cpol, input bit cpha, input bit lsbf);
    sck = cpol;
    repeat (10) @(negedge clk);
    csn = 1'b0;
    repeat (20) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      int k = b / 8;
      int j = b % 8;
      int bi = lsbf ? j : 7 - j;
      if (!cpha) begin
        mosi = mo[k][bi];
        repeat (HALF) @(negedge clk);
        mi[k][bi] = miso;
        sck = ~cpol;
        repeat (HALF) @(negedge clk);
        sck = cpol;
      end else begin
        sck = ~cpol;
        mosi = mo[k][bi];
        repeat (HALF) @(negedge clk);
        sck = cpol;
        mi[k][bi] = miso;
        repeat (HALF) @(negedge clk);
      end
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // driver: pushes expected writes, runs a frame, checks results
  task automatic xfer(input int nbits, input logic [1:0] md, input bit lsbf, input bit gr,
                      input int tl, input int rl, input logic [7:0] seed, input string tag);
    int nb = nbits / 8;
    int ends0 = ends;
    logic [IW-1:0] ptx = tx_cnt;
    logic [IW-1:0] prx = rx_cnt;
    logic [7:0] ex;
    @(negedge clk);
    mode = md; lsb = lsbf; grant = gr; txl = IW'(tl); rxl = IW'(rl);
    for (int k = 0; k < 16; k++) begin
      mo[k] = seed ^ 8'(k * 59);
      mi[k] = 8'h00;
    end
    if (gr) for (int k = 0; k < nb && k < rl; k++) exp_q.push_back({8'(k), mo[k]});
    spi_run(nbits, md[1], md[0], lsbf);
    for (int k = 0; k < nb; k++) begin
      ex = !gr ? DEFC : (k < tl ? txm[k] : OVRC);
      chk(mi[k] == ex, !gr ? "R9" : (k < tl ? tag : "R6"), "miso byte", int'(mi[k]), int'(ex));
    end
    if (gr && nb > rl) mdl_ovf = 1'b1;
    if (gr && nb > tl) mdl_ovr = 1'b1;
    chk((ends - ends0) == (gr ? 1 : 0), "R8", "end pulses per frame", ends - ends0, gr ? 1 : 0);
    if (gr) begin
      chk(int'(rx_cnt) == (nb < rl ? nb : rl), "R7", "rx amount", int'(rx_cnt), nb < rl ? nb : rl);
      chk(int'(tx_cnt) == (nb < tl ? nb : tl), "R7", "tx amount", int'(tx_cnt), nb < tl ? nb : tl);
    end else begin
      chk(rx_cnt == prx && tx_cnt == ptx, "R9", "amounts kept", int'({tx_cnt, rx_cnt}), int'({ptx, prx}));
    end
    chk(f_ovf == mdl_ovf, "R5", "overflow flag", int'(f_ovf), int'(mdl_ovf));
    chk(f_ovr == mdl_ovr, "R6", "over-read flag", int'(f_ovr), int'(mdl_ovr));
    chk(exp_q.size() == 0, "R2", "missing rx writes", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic clear_flags(input logic [1:0] bits);
    @(negedge clk);
    clr = bits;
    @(negedge clk);
    clr = 2'b00;
    if (bits[0]) mdl_ovr = 1'b0;
    if (bits[1]) mdl_ovf = 1'b0;
    @(negedge clk);
    chk(f_ovr == mdl_ovr, "R10", "over-read after clear", int'(f_ovr), int'(mdl_ovr));
    chk(f_ovf == mdl_ovf, "R10", "overflow after clear", int'(f_ovf), int'(mdl_ovf));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst = 1'b1; csn = 1'b1; sck = 1'b0; mosi = 1'b0; mode = 2'b00; lsb = 1'b0;
    grant = 1'b0; txl = '0; rxl = '0; clr = 2'b00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(miso == 1'b0 && end_p == 1'b0, "R1", "miso/end after reset", int'({miso, end_p}), 0);
    chk(f_ovr == 1'b0 && f_ovf == 1'b0, "R1", "flags after reset", int'({f_ovr, f_ovf}), 0);
    chk(tx_cnt == '0 && rx_cnt == '0, "R1", "amounts after reset", int'({tx_cnt, rx_cnt}), 0);
    chk(tx_rd_en == 1'b0 && rx_wr_en == 1'b0, "R1", "port strobes after reset", int'({tx_rd_en, rx_wr_en}), 0);

    // R3: all four modes, msb first
    xfer(24, 2'd0, 1'b0, 1'b1, 4, 4, 8'h3A, "R3");
    xfer(24, 2'd1, 1'b0, 1'b1, 4, 4, 8'hC5, "R3");
    xfer(24, 2'd2, 1'b0, 1'b1, 4, 4, 8'h69, "R3");
    xfer(24, 2'd3, 1'b0, 1'b1, 4, 4, 8'h1E, "R3");
    // R4: lsb first
    xfer(24, 2'd0, 1'b1, 1'b1, 4, 4, 8'h81, "R4");
    xfer(24, 2'd3, 1'b1, 1'b1, 4, 4, 8'hF2, "R4");
    // R5: receive overflow
    xfer(32, 2'd0, 1'b0, 1'b1, 8, 2, 8'h47, "R5");
    // R6: transmit over-read (overflow stays sticky)
    xfer(24, 2'd1, 1'b0, 1'b1, 1, 8, 8'hB3, "R6");
    // R10: clear overflow only, then over-read only
    clear_flags(2'b10);
    // R9: ungranted frame keeps flags and amounts
    xfer(24, 2'd2, 1'b0, 1'b0, 0, 0, 8'h2D, "R9");
    clear_flags(2'b01);
    // R12: partial trailing byte, then realigned frame
    xfer(19, 2'd0, 1'b0, 1'b1, 8, 8, 8'h95, "R12");
    xfer(16, 2'd0, 1'b0, 1'b1, 8, 8, 8'h0F, "R12");
    // R11: zero limits, no buffer reads, all over-read
    xfer(16, 2'd1, 1'b0, 1'b1, 0, 0, 8'h77, "R11");
    clear_flags(2'b11);

    finish_run();
  end
endmodule